// File: doc/BRIEF.md
# Receive Queue with Byte or Halfword Read Packing

This block buffers 8-bit frames delivered by a serial receive engine and hands them to a 32-bit register read port. Each frame arrives as a one-cycle strobe with its byte. The read side pops one entry per read strobe. It always shows the oldest readable entry on the data output.

A single mode input decides what one read returns. In byte mode every received byte becomes its own entry and is returned in bits 7:0. In halfword mode the first byte of a pair waits in a holding register. When its partner arrives, the two become one entry, returned little-endian in the low 16 bits. The reported level always counts read units, that is, entries, and never bytes. Software selects halfword mode only for transfers with an even byte count, so a leftover byte is not expected in normal use.

Dropping the enable empties the queue, forgets any held byte and clears the sticky overflow flag.

Top module: `rxq_pack`

## Requirements
- R1: After reset the level is 0, the empty flag is 1, the overflow flag is 0 and the read data is 0.
- R2: With mode low (byte mode), each accepted byte becomes one entry; the read data shows the oldest entry in bits 7:0 with bits 31:8 zero, and a read strobe removes it, in arrival order.
- R3: With mode high (halfword mode), two consecutive bytes form one entry; the read data shows the first byte in bits 7:0, the second in bits 15:8, and bits 31:16 zero.
- R4: In halfword mode the first byte of a pair is not readable: level and empty flag are unchanged until its partner arrives.
- R5: The level output equals the number of readable entries, from 0 up to the depth of 32, rising by one per stored entry and falling by one per read of a non-empty queue.
- R6: The empty flag is 1 exactly when the level is 0.
- R7: An entry that arrives while the queue holds 32 entries and no read happens in the same cycle is discarded and contents stay unchanged. The overflow flag then goes to 1 and stays 1 until the enable is dropped.
- R8: A read strobe on an empty queue leaves level, flags and contents unchanged, and the read data is 0 while the queue is empty.
- R9: A cycle with the enable low empties the queue, clears the held byte and the overflow flag; bytes arriving while the enable is low are ignored.
- R10: When an entry arrives on a full queue in the same cycle as a read, both take effect and the level stays at 32.
- R11: A byte arriving in byte mode discards any byte still held from halfword mode; the same happens after a cycle in byte mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Queue enable; low flushes all state |
| half_mode | input | 1 | 0: one byte per read, 1: two bytes packed per read |
| rx_vld | input | 1 | One-cycle strobe marking a received byte |
| rx_byte | input | 8 | Received byte |
| rd_req | input | 1 | Read strobe; pops the oldest entry if any |
| rd_data | output | 32 | Oldest entry, zero-extended; 0 when empty |
| level | output | 6 | Number of readable entries |
| empty | output | 1 | High when no entry is readable |
| overflow | output | 1 | Sticky flag for a discarded entry |

## Verification
The embedded properties take for granted that reset is held on the first clock edge and that every input carries a known value at each rising edge. They also assume that a read and a received byte may coincide in any cycle, including on a full or empty queue. The stimulus changes all inputs only at the falling edge, keeps each strobe to single cycles, and flips the mode only between bytes. It deliberately crosses the full and empty boundaries, abandons a half-built pair both by a mode change and by dropping the enable, and mixes reads into a full queue.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic {
        MODE_BYTE = 1'b0,
        MODE_HALF = 1'b1
    } rxq_mode_e;

    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
    } rxq_entry_t;

    localparam int RD_W = 32;

    function automatic logic [RD_W-1:0] widen_entry(input rxq_entry_t e);
        return {{(RD_W-16){1'b0}}, e.hi, e.lo};
    endfunction

endpackage

// File: rtl/rxq_packer.sv
module rxq_packer
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  rxq_mode_e  mode,
    input  logic       in_vld,
    input  logic [7:0] in_byte,
    output logic       wr_en,
    output rxq_entry_t wr_entry
);

    logic       hold_vld;
    logic [7:0] hold_byte;

    always_comb begin
        wr_en    = 1'b0;
        wr_entry = '0;
        if (en && in_vld) begin
            if (mode == MODE_BYTE) begin
                wr_en       = 1'b1;
                wr_entry.lo = in_byte;
            end else if (hold_vld) begin
                wr_en       = 1'b1;
                wr_entry.lo = hold_byte;
                wr_entry.hi = in_byte;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            hold_vld  <= 1'b0;
            hold_byte <= '0;
        end else if (mode == MODE_BYTE) begin
            hold_vld <= 1'b0;
        end else if (in_vld) begin
            hold_vld <= !hold_vld;
            if (!hold_vld) hold_byte <= in_byte;
        end
    end

    // R4
    first_held_chk: assert property (@(posedge clk) disable iff (rst)
        (en && mode == MODE_HALF && in_vld && !hold_vld) |=> hold_vld);

    // R4
    lone_byte_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_HALF && !hold_vld) |-> !wr_en);

endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          wr_en,
    input  rxq_entry_t    wr_entry,
    input  logic          rd_req,
    output rxq_entry_t    rd_entry,
    output logic [CW-1:0] count,
    output logic          drop
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    rxq_entry_t    mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;
    logic          pop, accept;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + AW'(1);
    endfunction

    assign pop    = rd_req && (cnt != '0) && !flush;
    assign accept = wr_en && ((cnt != FULL_CNT) || pop) && !flush;
    assign drop   = wr_en && !accept && !flush;

    always_ff @(posedge clk) begin
        if (accept) mem[wptr] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (accept) wptr <= bump(wptr);
            if (pop)    rptr <= bump(rptr);
            case ({accept, pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assign rd_entry = (cnt != '0) ? mem[rptr] : '0;
    assign count    = cnt;

    // R5
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL_CNT);

    // R8
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && cnt == '0 && !wr_en && !flush) |=> (cnt == '0));

    // R7
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !rd_req && cnt == FULL_CNT && !flush) |=> (cnt == FULL_CNT));

    // R10
    full_swap_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_req && cnt == FULL_CNT && !flush) |=> (cnt == FULL_CNT));

endmodule

// File: rtl/rxq_flag.sv
module rxq_flag (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic drop,
    output logic ovf
);

    always_ff @(posedge clk) begin
        if (rst || !en) ovf <= 1'b0;
        else if (drop)  ovf <= 1'b1;
    end

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf && en) |=> ovf);

endmodule

// File: rtl/rxq_pack.sv
module rxq_pack
    import rxq_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            half_mode,
    input  logic            rx_vld,
    input  logic [7:0]      rx_byte,
    input  logic            rd_req,
    output logic [RD_W-1:0] rd_data,
    output logic [CW-1:0]   level,
    output logic            empty,
    output logic            overflow
);

    rxq_mode_e  mode;
    logic       wr_en, drop;
    rxq_entry_t wr_entry, rd_entry;

    assign mode = half_mode ? MODE_HALF : MODE_BYTE;

    rxq_packer u_packer (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .mode     (mode),
        .in_vld   (rx_vld),
        .in_byte  (rx_byte),
        .wr_en    (wr_en),
        .wr_entry (wr_entry)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .flush    (!en),
        .wr_en    (wr_en),
        .wr_entry (wr_entry),
        .rd_req   (rd_req),
        .rd_entry (rd_entry),
        .count    (level),
        .drop     (drop)
    );

    rxq_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .drop (drop),
        .ovf  (overflow)
    );

    assign rd_data = widen_entry(rd_entry);
    assign empty   = (level == '0);

    // R9
    flush_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (empty && !overflow));

    // R8
    empty_data_chk: assert property (@(posedge clk) disable iff (rst)
        empty |-> (rd_data == '0));

endmodule

// File: tb/rxq_pack_tb.sv
module rxq_pack_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        half_mode = 1'b0;
    logic        rx_vld = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rd_req = 1'b0;
    logic [31:0] rd_data;
    logic [5:0]  level;
    logic        empty;
    logic        overflow;

    int n_chk = 0;
    int n_bad = 0;

    int   mq[$];
    bit   m_hold_vld = 0;
    int   m_hold = 0;
    bit   m_ovf = 0;

    always #5 clk = ~clk;

    rxq_pack u_dut (
        .clk(clk), .rst(rst), .en(en), .half_mode(half_mode),
        .rx_vld(rx_vld), .rx_byte(rx_byte), .rd_req(rd_req),
        .rd_data(rd_data), .level(level), .empty(empty), .overflow(overflow)
    );

    task automatic check(input string tag);
        int exp_lvl  = mq.size();
        int exp_data = (mq.size() > 0) ? mq[0] : 0;
        bit exp_emp  = (mq.size() == 0);
        n_chk++;
        if (int'(level) != exp_lvl || int'(rd_data) != exp_data ||
            empty != exp_emp || overflow != m_ovf) begin
            n_bad++;
            $display("FAIL %s: level=%0d data=%h empty=%0b ovf=%0b expected level=%0d data=%h empty=%0b ovf=%0b",
                     tag, level, rd_data, empty, overflow,
                     exp_lvl, exp_data[31:0], exp_emp, m_ovf);
        end
    endtask

    task automatic model_edge();
        bit pop, wr;
        int ent;
        if (!en) begin
            mq.delete();
            m_hold_vld = 0;
            m_ovf = 0;
            return;
        end
        pop = rd_req && mq.size() > 0;
        wr  = 0;
        ent = 0;
        if (rx_vld) begin
            if (!half_mode) begin
                wr = 1; ent = int'(rx_byte);
            end else if (m_hold_vld) begin
                wr = 1; ent = m_hold | (int'(rx_byte) << 8);
            end
        end
        if (pop) void'(mq.pop_front());
        if (wr) begin
            if (mq.size() < 32) mq.push_back(ent);
            else m_ovf = 1;
        end
        if (!half_mode) m_hold_vld = 0;
        else if (rx_vld) begin
            if (!m_hold_vld) m_hold = int'(rx_byte);
            m_hold_vld = !m_hold_vld;
        end
    endtask

    task automatic step(input bit v, input logic [7:0] b, input bit r, input string tag);
        rx_vld  = v;
        rx_byte = b;
        rd_req  = r;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        rx_vld = 0;
        rd_req = 0;
        check(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1");
        en = 1'b1;

        // R2: byte mode ordering
        step(1, 8'h11, 0, "R2");
        step(1, 8'h22, 0, "R2");
        step(1, 8'h33, 0, "R6");
        for (int i = 0; i < 3; i++) step(0, 8'h00, 1, "R2");
        // R8: reads on empty
        step(0, 8'h00, 1, "R8");
        step(0, 8'h00, 1, "R8");

        // R3/R4: halfword packing
        half_mode = 1'b1;
        step(1, 8'hA1, 0, "R4");
        step(1, 8'hB2, 0, "R3");
        step(1, 8'hC3, 0, "R4");
        step(1, 8'hD4, 1, "R3");
        step(0, 8'h00, 1, "R3");

        // R11: mode change discards held byte
        step(1, 8'h77, 0, "R4");
        half_mode = 1'b0;
        step(1, 8'h55, 0, "R11");
        step(0, 8'h00, 1, "R11");
        half_mode = 1'b1;
        step(1, 8'h66, 0, "R11");
        half_mode = 1'b0;
        step(0, 8'h00, 0, "R11");
        half_mode = 1'b1;
        step(1, 8'h88, 0, "R11");
        step(1, 8'h99, 0, "R11");
        step(0, 8'h00, 1, "R11");
        half_mode = 1'b0;

        // R5/R7/R10: fill, overflow, swap on full
        for (int i = 0; i < 32; i++) step(1, 8'(i + 8'h40), 0, "R5");
        step(1, 8'hEE, 0, "R7");
        step(1, 8'hEF, 1, "R10");
        step(0, 8'h00, 0, "R7");
        for (int i = 0; i < 32; i++) step(0, 8'h00, 1, "R5");
        step(0, 8'h00, 1, "R8");

        // R9: flush clears pending byte, entries and flag
        half_mode = 1'b1;
        step(1, 8'h12, 0, "R4");
        step(1, 8'h34, 0, "R3");
        step(1, 8'h56, 0, "R4");
        en = 1'b0;
        step(0, 8'h00, 0, "R9");
        step(1, 8'h78, 0, "R9");
        en = 1'b1;
        step(1, 8'h9A, 0, "R9");
        step(1, 8'hBC, 0, "R9");

        // R7 in halfword mode
        for (int i = 0; i < 62; i++) step(1, 8'(i), 0, "R5");
        step(1, 8'hF0, 0, "R4");
        step(1, 8'hF1, 0, "R7");
        step(0, 8'h00, 1, "R7");
        en = 1'b0;
        step(0, 8'h00, 0, "R9");
        en = 1'b1;
        step(0, 8'h00, 0, "R9");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run still busy expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule